// File: doc/BRIEF.md
# Video line and frame timing generator

This block derives raster timing from the system clock. A divider cuts the clock into line periods, and a line counter tracks the position of the current line within a frame. From that one count the block drives a vertical-blank level, a one-clock pulse when blanking begins, a one-clock frame-wrap interrupt, and an audio-update tick that fires once every 32 lines. It also brings out the end-of-line tick so that a neighbouring timer can count scanlines.

A single select input chooses between two television standards. The 60 Hz standard has 263 lines per frame, and blanking starts at line 240. The 50 Hz standard has 313 lines per frame, and blanking starts at line 256. The line period in clocks is the clock frequency divided by the product of the frame rate and the number of lines per frame. The block reads the select input at reset and again at each frame wrap, so a change never breaks up a frame that is already running.

Top module: `lt_video_timing`

## Requirements
- R1: `hsync_tick` is high for exactly the last clock of each line period. A line period is CLK_HZ/(60*263) clocks when `std_sel`=0 and CLK_HZ/(50*313) clocks when `std_sel`=1 (integer division).
- R2: `line_num` advances by one on the clock edge that ends a line period. It runs from 0 to total-1, where total is 263 for `std_sel`=0 and 313 for `std_sel`=1.
- R3: `vblank` is high exactly while `line_num` is at least the blanking line: 240 for `std_sel`=0 and 256 for `std_sel`=1.
- R4: When the last line of a frame ends, `line_num` returns to 0. `vblank_irq` is then high for the first clock of line 0 only, and it is not raised by reset.
- R5: `vblank_start` is high for exactly the first clock of the blanking line.
- R6: `audio_tick` is high for the first clock of every line whose count of lines since reset is a nonzero multiple of 32. This count does not restart at a frame wrap.
- R7: `std_sel` is sampled during reset and at each frame wrap. A change in mid-frame has no effect on the line total or the blanking line until the next wrap.
- R8: Reset is synchronous and active high. While it is asserted, `line_num` is 0 and every pulse output and `vblank` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| std_sel | input | 1 | Standard select: 0 = 60 Hz / 263 lines, 1 = 50 Hz / 313 lines |
| hsync_tick | output | 1 | High during the last clock of each line |
| line_num | output | LINE_W (9) | Current line within the frame |
| vblank | output | 1 | Vertical blanking level |
| vblank_start | output | 1 | One-clock pulse on the first clock of the blanking line |
| vblank_irq | output | 1 | One-clock interrupt pulse on the first clock of a new frame |
| audio_tick | output | 1 | One-clock pulse every 32 lines |

## Verification
The end-of-line tick is combinational from the divider and is high during the last clock of a line. `line_num` and `vblank` take their new values on the edge that ends that clock. `vblank_start`, `vblank_irq` and `audio_tick` are registered on the same edge, so they appear in the first clock of the new line. After N clock edges from reset release, the expected line is therefore floor(N/P) modulo the total. The bench counts exact rising edges from reset release and samples at the falling edge that follows. It also samples one edge before and one edge after each pulse, which confirms that each pulse lasts a single clock.

// File: rtl/lt_pkg.sv
package lt_pkg;

    typedef enum logic {
        STD_60 = 1'b0,
        STD_50 = 1'b1
    } vstd_e;

    localparam int LINE_W      = 9;
    localparam int AUDIO_LINES = 32;

    function automatic int lines_per_frame(vstd_e s);
        return (s == STD_50) ? 313 : 263;
    endfunction

    function automatic int blank_line(vstd_e s);
        return (s == STD_50) ? 256 : 240;
    endfunction

    function automatic int frame_hz(vstd_e s);
        return (s == STD_50) ? 50 : 60;
    endfunction

    function automatic int line_clocks(int clk_hz, vstd_e s);
        return clk_hz / (frame_hz(s) * lines_per_frame(s));
    endfunction

endpackage

// File: rtl/lt_line_div.sv
module lt_line_div
    import lt_pkg::*;
#(
    parameter int P60 = 4,
    parameter int P50 = 4,
    parameter int W   = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  vstd_e std_q,
    output logic  tick
);
    logic [W-1:0] cnt;
    logic [W-1:0] last;

    assign last = (std_q == STD_50) ? W'(P50 - 1) : W'(P60 - 1);
    assign tick = (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= last); // R1
    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R1
endmodule

// File: rtl/lt_line_ctr.sv
module lt_line_ctr
    import lt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  vstd_e             std_in,
    input  logic              tick,
    output vstd_e             std_q,
    output logic [LINE_W-1:0] line_q,
    output logic              vblank,
    output logic              vbs_q,
    output logic              irq_q
);
    logic              wrap;
    logic [LINE_W-1:0] line_nx;

    assign wrap    = (line_q == LINE_W'(lines_per_frame(std_q) - 1));
    assign line_nx = line_q + 1'b1;
    assign vblank  = (line_q >= LINE_W'(blank_line(std_q)));

    always_ff @(posedge clk) begin
        if (rst) begin
            std_q  <= std_in;
            line_q <= '0;
            vbs_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            vbs_q <= tick && !wrap && (line_nx == LINE_W'(blank_line(std_q)));
            irq_q <= tick && wrap;
            if (tick) begin
                if (wrap) begin
                    line_q <= '0;
                    std_q  <= std_in;
                end else begin
                    line_q <= line_nx;
                end
            end
        end
    end

    AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
        line_q < LINE_W'(lines_per_frame(std_q))); // R2
    AST_IRQ_LINE0: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (line_q == '0) && !vblank); // R4
    AST_VBS_LINE: assert property (@(posedge clk) disable iff (rst)
        vbs_q |-> vblank && (line_q == LINE_W'(blank_line(std_q)))); // R5
    AST_STD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(tick && wrap) |=> $stable(std_q)); // R7
endmodule

// File: rtl/lt_audio_tick.sv
module lt_audio_tick
    import lt_pkg::*;
#(
    parameter int N = AUDIO_LINES
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic pulse
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (tick) begin
            if (cnt == CW'(N - 1)) begin
                cnt   <= '0;
                pulse <= 1'b1;
            end else begin
                cnt   <= cnt + 1'b1;
                pulse <= 1'b0;
            end
        end else begin
            pulse <= 1'b0;
        end
    end

    AST_AUDIO_PULSE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R6
    AST_AUDIO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(tick)); // R6
endmodule

// File: rtl/lt_video_timing.sv
module lt_video_timing
    import lt_pkg::*;
#(
    parameter int CLK_HZ = 33868800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              std_sel,
    output logic              hsync_tick,
    output logic [LINE_W-1:0] line_num,
    output logic              vblank,
    output logic              vblank_start,
    output logic              vblank_irq,
    output logic              audio_tick
);
    localparam int P60   = line_clocks(CLK_HZ, STD_60);
    localparam int P50   = line_clocks(CLK_HZ, STD_50);
    localparam int PMAX  = (P60 > P50) ? P60 : P50;
    localparam int PER_W = $clog2(PMAX) + 1;

    vstd_e std_q;

    lt_line_div #(.P60(P60), .P50(P50), .W(PER_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .std_q (std_q),
        .tick  (hsync_tick)
    );

    lt_line_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .std_in (vstd_e'(std_sel)),
        .tick   (hsync_tick),
        .std_q  (std_q),
        .line_q (line_num),
        .vblank (vblank),
        .vbs_q  (vblank_start),
        .irq_q  (vblank_irq)
    );

    lt_audio_tick #(.N(AUDIO_LINES)) u_aud (
        .clk   (clk),
        .rst   (rst),
        .tick  (hsync_tick),
        .pulse (audio_tick)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (line_num == '0) && !vblank_irq && !audio_tick && !vblank_start); // R8
endmodule

// File: tb/lt_video_timing_test.sv
module lt_video_timing_test;
    import lt_pkg::*;

    // CLK_HZ 63120 gives a 4-clock line for both standards
    localparam int CLK_HZ = 63120;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       std_sel = 1'b0;
    logic       hsync_tick, vblank, vblank_start, vblank_irq, audio_tick;
    logic [8:0] line_num;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lt_video_timing #(.CLK_HZ(CLK_HZ)) uut (
        .clk          (clk),
        .rst          (rst),
        .std_sel      (std_sel),
        .hsync_tick   (hsync_tick),
        .line_num     (line_num),
        .vblank       (vblank),
        .vblank_start (vblank_start),
        .vblank_irq   (vblank_irq),
        .audio_tick   (audio_tick)
    );

    // {std(1), edges(16), line(9), vblank(1)}
    localparam logic [26:0] VEC [12] = '{
        {1'b0, 16'd0,    9'd0,   1'b0},
        {1'b0, 16'd4,    9'd1,   1'b0},
        {1'b0, 16'd959,  9'd239, 1'b0},
        {1'b0, 16'd960,  9'd240, 1'b1},
        {1'b0, 16'd1051, 9'd262, 1'b1},
        {1'b0, 16'd1052, 9'd0,   1'b0},
        {1'b0, 16'd1056, 9'd1,   1'b0},
        {1'b1, 16'd1023, 9'd255, 1'b0},
        {1'b1, 16'd1024, 9'd256, 1'b1},
        {1'b1, 16'd1251, 9'd312, 1'b1},
        {1'b1, 16'd1252, 9'd0,   1'b0},
        {1'b1, 16'd1256, 9'd1,   1'b0}
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(logic s);
        @(negedge clk);
        rst = 1'b1;
        std_sel = s;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic adv(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R8: outputs during reset
        do_reset(1'b0);
        rst = 1'b1;
        adv(1);
        chk("R8 line", int'(line_num), 0);
        chk("R8 pulses", int'({vblank, vblank_start, vblank_irq, audio_tick, hsync_tick}), 0);

        // R2 R3 table walk
        for (int i = 0; i < 12; i++) begin
            do_reset(VEC[i][26]);
            adv(int'(VEC[i][25:10]));
            chk("R2 line_num", int'(line_num), int'(VEC[i][9:1]));
            chk("R3 vblank", int'(vblank), int'(VEC[i][0]));
        end

        // R1: tick during last clock of the line
        do_reset(1'b0);
        adv(3);
        chk("R1 tick high", int'(hsync_tick), 1);
        adv(1);
        chk("R1 tick low", int'(hsync_tick), 0);
        adv(6);
        chk("R1 tick second line", int'(hsync_tick), 0);
        adv(1);
        chk("R1 tick second line end", int'(hsync_tick), 1);

        // R5 R6 R4 on 60 Hz
        do_reset(1'b0);
        adv(124);
        chk("R6 before", int'(audio_tick), 0);
        adv(4);
        chk("R6 line 32", int'(audio_tick), 1);
        adv(1);
        chk("R6 one clock", int'(audio_tick), 0);
        adv(956 - 129);
        chk("R5 before", int'(vblank_start), 0);
        adv(4);
        chk("R5 line 240", int'(vblank_start), 1);
        adv(1);
        chk("R5 one clock", int'(vblank_start), 0);
        adv(1051 - 961);
        chk("R4 before wrap", int'(vblank_irq), 0);
        adv(1);
        chk("R4 irq", int'(vblank_irq), 1);
        chk("R4 line 0", int'(line_num), 0);
        adv(1);
        chk("R4 one clock", int'(vblank_irq), 0);
        adv(1152 - 1053);
        chk("R6 across wrap line 288", int'(audio_tick), 1);
        chk("R6 line", int'(line_num), 25);

        // R7: mid-frame change deferred to wrap
        do_reset(1'b0);
        adv(10);
        std_sel = 1'b1;
        adv(950);
        chk("R7 old blank line", int'(vblank), 1);
        adv(1052 - 960);
        chk("R7 old total wrap", int'(line_num), 0);
        adv(960);
        chk("R7 new blank not yet", int'(vblank), 0);
        adv(64);
        chk("R7 new blank line 256", int'(vblank), 1);
        chk("R7 new line", int'(line_num), 256);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule